// File: doc/BRIEF.md
# HCS Slot Delineation Engine

This block recovers the boundaries of fixed 53-octet slots carried back to back in the payload area of a synchronous container. Each slot starts with a five-octet header. The fifth header octet is a check sequence computed over the first three header octets. The block watches an octet stream, tests candidate header positions against that check and, once it trusts a position, marks slot starts and header octets for the logic behind it.

The input is one octet per cycle with a valid strobe and a payload qualifier. Overhead and fixed-stuff octets arrive with the qualifier low. They are not counted, so a slot that is split across two container frames keeps its alignment. Acquisition has three states. In the search state every octet is a candidate header end. The confirm state needs a run of correct checks at the expected positions before lock is declared. In the locked state, only a run of failed checks drops the block back to search. The lock output feeds a downstream loss-of-delineation indication. Locating the container frame, payload descrambling and header error correction belong to other blocks.

Top module: `slot_delineator`

## Requirements
- R1: A header matches when CRC-8 (generator x^8+x^2+x+1, initial value zero, most significant bit first) over header octets 0, 1 and 2, XORed with 8'h55, equals header octet 4. Header octet 3 takes no part in the check.
- R2: Only an octet with `in_valid` and `in_pay` both high is accepted. Any other cycle leaves the header window, the slot position and the state unchanged, and drives both markers low.
- R3: In the search state every accepted octet is tested as header octet 4, using the last five accepted octets. No match is possible before five octets have been accepted since reset. A match moves to the confirm state, and that octet becomes header octet 4.
- R4: In the confirm state the check is evaluated only at header octet 4 of each slot. One failure returns to search. `PRESYNC_N` (default 6) consecutive passes move to the locked state.
- R5: In the locked state, `MISS_N` (default 7) consecutive failed checks return to search. A passing check clears the failure run, so `MISS_N`-1 failures followed by a pass keep lock.
- R6: `slot_lock` is high exactly while the block is in the locked state. It changes in the cycle after the octet that causes the transition is accepted.
- R7: One cycle after an accepted octet, `hdr_phase` is high if that octet is slot octet 0 to 4 and the resulting state is confirm or locked. `slot_start` is high under the same condition for slot octet 0 only. Both are low after the search state.
- R8: The slot position advances by one per accepted octet and wraps after octet 52. It holds across any number of non-payload cycles.
- R9: Reset clears both markers, drops lock, returns the state to search and empties the header window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An octet is present on `in_octet` this cycle |
| in_pay | input | 1 | The present octet belongs to the container payload |
| in_octet | input | 8 | Received octet |
| slot_start | output | 1 | The previous accepted octet was the first octet of a slot |
| hdr_phase | output | 1 | The previous accepted octet was one of the five header octets |
| slot_lock | output | 1 | Delineation is in the locked state |

## Verification
The stimulus places slots at odd offsets and cuts them with non-payload cycles of both kinds. A design that counted those cycles, or shifted them into the header window, would lose alignment and drop its markers. Two streams separate the thresholds by one slot each. A run of six corrupted headers while locked must keep lock, and a run of seven must lose it and then reacquire. A design that reset or failed to reset the failure run on a good header would be off by one there. A confirm attempt that is one good slot short must stay unlocked. A short stream that matches only if the empty window is treated as zeros exposes a window that reports hits before it is full. Payload octets are rearranged so that no stray window matches. A wrong generator, a missing 8'h55 pattern, or a check that includes octet 3 therefore never locks at all.

// File: rtl/slot_delin_pkg.sv
`timescale 1ns/1ps
package slot_delin_pkg;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } delin_st_e;

  // header octets protected by the check sequence
  localparam int COVER_OCTETS = 3;
  localparam logic [7:0] HCS_POLY = 8'h07;

  // serial CRC-8, MSB first, zero start value
  function automatic logic [7:0] hcs_calc(input logic [8*COVER_OCTETS-1:0] hdr);
    logic [7:0] c;
    logic       fb;
    c = '0;
    for (int i = 8*COVER_OCTETS-1; i >= 0; i--) begin
      fb = c[7] ^ hdr[i];
      c  = {c[6:0], 1'b0} ^ (fb ? HCS_POLY : 8'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/hcs_window.sv
`timescale 1ns/1ps
module hcs_window
  import slot_delin_pkg::*;
#(
  parameter int         HDR_OCTETS = 5,
  parameter logic [7:0] COSET      = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic [7:0] din,
  output logic       hit
);
  localparam int STAGES = HDR_OCTETS - 1;
  localparam int FILL_W = $clog2(STAGES + 1);
  localparam logic [FILL_W-1:0] FULL_N = FILL_W'(STAGES);

  // oldest octet in the top byte, newest stored octet in the low byte
  logic [8*STAGES-1:0]     shift_q;
  logic [8*HDR_OCTETS-1:0] win;
  logic [FILL_W-1:0]       fill_q;
  logic                    full;
  logic [7:0]              calc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      fill_q  <= '0;
    end else if (acc) begin
      shift_q <= {shift_q[8*STAGES-9:0], din};
      if (fill_q != FULL_N) fill_q <= fill_q + 1'b1;
    end
  end

  assign win  = {shift_q, din};
  assign full = (fill_q == FULL_N);
  assign calc = hcs_calc(win[8*HDR_OCTETS-1 -: 8*COVER_OCTETS]) ^ COSET;
  assign hit  = full && (calc == win[7:0]);

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(shift_q) && $stable(fill_q)); // R2

endmodule

// File: rtl/slot_pos_ctr.sv
`timescale 1ns/1ps
module slot_pos_ctr #(
  parameter int SLOT_OCTETS = 53,
  parameter int HDR_OCTETS  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic realign,
  output logic at_chk,
  output logic at_first,
  output logic in_hdr
);
  localparam int POS_W = $clog2(SLOT_OCTETS);
  localparam logic [POS_W-1:0] LAST  = POS_W'(SLOT_OCTETS - 1);
  localparam logic [POS_W-1:0] CHK   = POS_W'(HDR_OCTETS - 1);
  localparam logic [POS_W-1:0] AFTER = POS_W'(HDR_OCTETS);
  localparam logic [POS_W-1:0] HLEN  = POS_W'(HDR_OCTETS);

  // cnt_q holds the slot index of the next octet to be accepted
  logic [POS_W-1:0] cnt_q;
  logic [POS_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (acc) begin
      if (realign)           cnt_q <= AFTER;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  // a fresh match makes the current octet the last header octet
  assign idx      = realign ? CHK : cnt_q;
  assign at_chk   = (idx == CHK);
  assign at_first = (idx == '0);
  assign in_hdr   = (idx < HLEN);

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(cnt_q)); // R8

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R8

endmodule

// File: rtl/delin_fsm.sv
`timescale 1ns/1ps
module delin_fsm
  import slot_delin_pkg::*;
#(
  parameter int PRESYNC_N = 6,
  parameter int MISS_N    = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc,
  input  logic      hit,
  input  logic      at_chk,
  output delin_st_e st_q,
  output delin_st_e st_nx,
  output logic      realign
);
  localparam int GW = $clog2(PRESYNC_N + 1);
  localparam int MW = $clog2(MISS_N + 1);
  localparam logic [GW-1:0] GOOD_END = GW'(PRESYNC_N - 1);
  localparam logic [MW-1:0] MISS_END = MW'(MISS_N - 1);

  logic [GW-1:0] good_q, good_nx;
  logic [MW-1:0] miss_q, miss_nx;

  assign realign = acc && (st_q == ST_HUNT) && hit;

  always_comb begin
    st_nx   = st_q;
    good_nx = good_q;
    miss_nx = miss_q;
    if (acc) begin
      unique case (st_q)
        ST_HUNT: begin
          if (hit) begin
            st_nx   = ST_PRESYNC;
            good_nx = '0;
          end
        end
        ST_PRESYNC: begin
          if (at_chk) begin
            if (!hit) st_nx = ST_HUNT;
            else if (good_q == GOOD_END) begin
              st_nx   = ST_SYNC;
              miss_nx = '0;
            end else good_nx = good_q + 1'b1;
          end
        end
        ST_SYNC: begin
          if (at_chk) begin
            if (hit) miss_nx = '0;
            else if (miss_q == MISS_END) st_nx = ST_HUNT;
            else miss_nx = miss_q + 1'b1;
          end
        end
        default: st_nx = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      miss_q <= '0;
    end else begin
      st_q   <= st_nx;
      good_q <= good_nx;
      miss_q <= miss_nx;
    end
  end

  AST_HUNT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_HUNT && st_q != ST_HUNT) |-> ($past(acc && hit) && st_q == ST_PRESYNC)); // R3

  AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) != ST_SYNC && st_q == ST_SYNC) |-> ($past(st_q) == ST_PRESYNC && $past(acc && at_chk && hit))); // R4

  AST_SYNC_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_SYNC && st_q != ST_SYNC) |-> ($past(acc && at_chk && !hit) && $past(miss_q) == MISS_END)); // R5

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(st_q)); // R2

endmodule

// File: rtl/slot_delineator.sv
`timescale 1ns/1ps
module slot_delineator
  import slot_delin_pkg::*;
#(
  parameter int         SLOT_OCTETS = 53,
  parameter int         HDR_OCTETS  = 5,
  parameter int         PRESYNC_N   = 6,
  parameter int         MISS_N      = 7,
  parameter logic [7:0] HCS_COSET   = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_pay,
  input  logic [7:0] in_octet,
  output logic       slot_start,
  output logic       hdr_phase,
  output logic       slot_lock
);
  logic      acc;
  logic      hit;
  logic      realign;
  logic      at_chk;
  logic      at_first;
  logic      in_hdr;
  delin_st_e st_q;
  delin_st_e st_nx;

  assign acc = in_valid & in_pay;

  hcs_window #(
    .HDR_OCTETS (HDR_OCTETS),
    .COSET      (HCS_COSET)
  ) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (acc),
    .din   (in_octet),
    .hit   (hit)
  );

  slot_pos_ctr #(
    .SLOT_OCTETS (SLOT_OCTETS),
    .HDR_OCTETS  (HDR_OCTETS)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .realign  (realign),
    .at_chk   (at_chk),
    .at_first (at_first),
    .in_hdr   (in_hdr)
  );

  delin_fsm #(
    .PRESYNC_N (PRESYNC_N),
    .MISS_N    (MISS_N)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .hit     (hit),
    .at_chk  (at_chk),
    .st_q    (st_q),
    .st_nx   (st_nx),
    .realign (realign)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_start <= 1'b0;
      hdr_phase  <= 1'b0;
    end else begin
      slot_start <= acc && (st_nx != ST_HUNT) && at_first;
      hdr_phase  <= acc && (st_nx != ST_HUNT) && in_hdr;
    end
  end

  assign slot_lock = (st_q == ST_SYNC);

  AST_START_IN_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> hdr_phase); // R7

  AST_MARK_ON_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start || hdr_phase) |-> $past(in_valid && in_pay)); // R7

endmodule

// File: tb/slot_delineator_tb.sv
`timescale 1ns/1ps
module slot_delineator_tb;
  localparam int SLOT   = 53;
  localparam int HDR    = 5;
  localparam int PRE_N  = 6;
  localparam int MISS_N = 7;
  localparam int MAXO   = 1400;
  localparam int MAXS   = 26;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_pay = 1'b0;
  logic [7:0] in_octet = 8'h00;
  logic       slot_start, hdr_phase, slot_lock;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  slot_delineator #(
    .SLOT_OCTETS (SLOT),
    .HDR_OCTETS  (HDR),
    .PRESYNC_N   (PRE_N),
    .MISS_N      (MISS_N),
    .HCS_COSET   (8'h55)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_pay     (in_pay),
    .in_octet   (in_octet),
    .slot_start (slot_start),
    .hdr_phase  (hdr_phase),
    .slot_lock  (slot_lock)
  );

  // prefix octets, slots, first bad slot, bad run length, gap period, lock at end
  localparam int NSCN = 6;
  localparam int SCN [NSCN][6] = '{
    '{ 0,  9, 0, 0,  0, 1},   // R4 R6 aligned start
    '{17, 10, 0, 0,  7, 1},   // R2 R3 R8 odd offset, gaps
    '{ 3, 20, 9, 6,  0, 1},   // R5 one short of loss
    '{ 0, 24, 8, 7, 11, 1},   // R5 loss and reacquire
    '{ 5, 12, 3, 1,  0, 1},   // R4 confirm failure
    '{ 2,  6, 0, 0,  0, 0}    // R4 one pass short of lock
  };

  logic [7:0] strm    [MAXO];
  bit         modok   [MAXO];
  bit         goodchk [MAXO];
  int         slot_of [MAXO];
  int         pos_of  [MAXO];
  int         st_after[MAXS];
  int         n_oct;

  // CRC by polynomial long division (R1)
  function automatic logic [7:0] ref_hcs(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    logic [31:0] m;
    m = {a, b, c, 8'h00};
    for (int i = 31; i >= 8; i--)
      if (m[i]) m = m ^ (32'h0000_0107 << (i - 8));
    return m[7:0];
  endfunction

  function automatic bit win_hit(input int e);
    return (ref_hcs(strm[e-4], strm[e-3], strm[e-2]) ^ 8'h55) == strm[e];
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic p, input logic [7:0] d);
    in_valid = v;
    in_pay   = p;
    in_octet = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    in_pay   = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic build(input int prefix, input int ns, input int bf, input int bc);
    n_oct = 0;
    for (int i = 0; i < prefix; i++) begin
      strm[n_oct] = 8'($urandom); modok[n_oct] = 1'b1; goodchk[n_oct] = 1'b0;
      slot_of[n_oct] = -1; pos_of[n_oct] = -1; n_oct++;
    end
    for (int s = 0; s < ns; s++) begin
      bit bad;
      bad = (s >= bf) && (s < bf + bc);
      for (int j = 0; j < SLOT; j++) begin
        if (j < 4) strm[n_oct] = 8'($urandom);
        else if (j == 4)
          strm[n_oct] = ref_hcs(strm[n_oct-4], strm[n_oct-3], strm[n_oct-2]) ^ 8'h55 ^ (bad ? 8'h01 : 8'h00);
        else strm[n_oct] = 8'($urandom);
        modok[n_oct]   = (j >= HDR);
        goodchk[n_oct] = (j == 4) && !bad;
        slot_of[n_oct] = s;
        pos_of[n_oct]  = j;
        n_oct++;
      end
    end
    // rewrite payload so only true headers can match
    for (int pass = 0; pass < 60; pass++) begin
      bit dirty;
      dirty = 1'b0;
      for (int e = 4; e < n_oct; e++) begin
        if (!goodchk[e] && win_hit(e)) begin
          for (int k = e; k >= e - 4; k--) begin
            if (modok[k]) begin
              strm[k] = strm[k] ^ 8'h3C;
              dirty = 1'b1;
              break;
            end
          end
        end
      end
      if (!dirty) break;
    end
    // slot-level expectation from R3 R4 R5
    begin
      int st, g, m;
      st = 0; g = 0; m = 0;
      for (int s = 0; s < ns; s++) begin
        bit good;
        good = !((s >= bf) && (s < bf + bc));
        case (st)
          0: if (good) begin st = 1; g = 0; end
          1: if (!good) st = 0;
             else if (g == PRE_N - 1) begin st = 2; m = 0; end
             else g++;
          default: if (good) m = 0;
             else if (m == MISS_N - 1) st = 0;
             else m++;
        endcase
        st_after[s] = st;
      end
    end
  endtask

  task automatic run_scn(input int k);
    int gap;
    gap = SCN[k][4];
    build(SCN[k][0], SCN[k][1], SCN[k][2], SCN[k][3]);
    do_reset();
    for (int i = 0; i < n_oct; i++) begin
      int es;
      bit eh, ef;
      if (slot_of[i] < 0) es = 0;
      else if (pos_of[i] < HDR - 1) es = (slot_of[i] == 0) ? 0 : st_after[slot_of[i] - 1];
      else es = st_after[slot_of[i]];
      eh = (es != 0) && (pos_of[i] >= 0) && (pos_of[i] < HDR);
      ef = (es != 0) && (pos_of[i] == 0);
      drive(1'b1, 1'b1, strm[i]);
      chk(hdr_phase, eh, $sformatf("R7 hdr_phase scn%0d octet%0d", k, i));
      chk(slot_start, ef, $sformatf("R7 slot_start scn%0d octet%0d", k, i));
      chk(slot_lock, es == 2, $sformatf("R1/R6 slot_lock scn%0d octet%0d", k, i));
      if (gap != 0 && (i % gap) == gap - 1) begin
        drive(1'b1, 1'b0, 8'($urandom));
        chk(hdr_phase | slot_start, 1'b0, $sformatf("R2 marker on payload-low gap scn%0d", k));
        drive(1'b0, 1'b1, 8'($urandom));
        chk(hdr_phase | slot_start, 1'b0, $sformatf("R2 marker on valid-low gap scn%0d", k));
        chk(slot_lock, es == 2, $sformatf("R8 lock across gap scn%0d", k));
      end
    end
    in_valid = 1'b0;
    in_pay   = 1'b0;
    chk(slot_lock, SCN[k][5] != 0, $sformatf("R4/R5 final lock scn%0d", k));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R9 reset state
    do_reset();
    chk(slot_start, 1'b0, "R9 slot_start after reset");
    chk(hdr_phase, 1'b0, "R9 hdr_phase after reset");
    chk(slot_lock, 1'b0, "R9 slot_lock after reset");

    // R3 window must be full: 00 00 00 55 would match against an all-zero oldest octet
    drive(1'b1, 1'b1, 8'h00); chk(hdr_phase, 1'b0, "R3 partial window octet1");
    drive(1'b1, 1'b1, 8'h00); chk(hdr_phase, 1'b0, "R3 partial window octet2");
    drive(1'b1, 1'b1, 8'h00); chk(hdr_phase, 1'b0, "R3 partial window octet3");
    drive(1'b1, 1'b1, 8'h55); chk(hdr_phase, 1'b0, "R3 partial window octet4");
    drive(1'b1, 1'b1, 8'h55); chk(hdr_phase, 1'b1, "R3 first full window match");
    chk(slot_start, 1'b0, "R7 match octet is not a slot start");
    chk(slot_lock, 1'b0, "R6 no lock in confirm state");
    in_valid = 1'b0;
    in_pay   = 1'b0;

    for (int k = 0; k < NSCN; k++) run_scn(k);

    // R9 reset while locked
    run_scn(0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(slot_lock, 1'b0, "R9 lock cleared by reset");
    chk(hdr_phase | slot_start, 1'b0, "R9 markers cleared by reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(slot_lock, 1'b0, "R9 search state after reset release");

    summary();
    $finish;
  end

endmodule